// File: doc/BRIEF.md
# Stack Push/Pop and Call/Return Sequencer

This block runs the four stack instructions of a small processor core: push, pop, call and return. It owns a word-wide stack-pointer register. It talks to a byte-addressed memory through a single request port that moves one 32-bit word per access. The stack grows toward lower addresses and moves one word (4 bytes) per step. A push or call first lowers the pointer and then writes at the new address. A pop or return reads at the current address and then raises the pointer.

The decoder gives the sequencer a command together with three values: the source register value, the call target and the address of the next instruction. The sequencer keeps its request to memory until the memory acknowledges it. One cycle after the acknowledge it raises a one-cycle completion pulse. In that cycle the new stack pointer, the popped value with its destination register index, and the new program counter are all valid. Words are little-endian: bits 7:0 of a word belong at the request address and bits 31:24 at that address plus 3.

If the stack pointer is not word aligned, the command is refused without touching memory and an error is flagged. This can only happen after a pop into the stack pointer has loaded it with an arbitrary value.

Top module: `stack_seq`

## Requirements
- R1: After a synchronous active-low reset the stack pointer equals the parameter `SP_INIT` (default 0x100), and busy, done, err, mem_req, res_wen and pc_wen are all low.
- R2: A push (cmd_op = 0) issues a write of src_val to address sp-4. After the acknowledge, sp_out equals sp-4.
- R3: A pop (cmd_op = 1) issues a read at address sp. On completion res_val holds the word read, res_dst holds cmd_dst and res_wen pulses, and sp_out becomes sp+4.
- R4: A call (cmd_op = 2) writes next_pc to address sp-4 and lowers sp by 4. On completion pc_val equals call_target and pc_wen pulses.
- R5: A return (cmd_op = 3) reads the word at sp. On completion pc_val holds that word and pc_wen pulses, sp_out becomes sp+4, and res_wen stays low.
- R6: A command is accepted only on a clock edge where busy is low and cmd_valid is high. From the next cycle mem_req stays high, with address, direction and write data unchanged, until the edge at which mem_ack is high. done pulses for exactly one cycle, the cycle after that edge.
- R7: A pop whose destination index equals the stack-pointer index 4 leaves the stack pointer equal to the word read, not to the incremented address.
- R8: If the low two bits of the stack pointer are nonzero when a command is accepted, err and done pulse together in the next cycle. No memory request is made, and the stack pointer, res_wen and pc_wen are unchanged.
- R9: cmd_valid pulses while busy is high have no effect. The command in progress completes with its own address, data and results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| cmd_dst | input | 4 | Destination register index for a pop |
| src_val | input | 32 | Value to push |
| call_target | input | 32 | Absolute destination of a call |
| next_pc | input | 32 | Address of the following instruction |
| busy | output | 1 | A memory access is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Word to write, little-endian |
| mem_rdata | input | 32 | Word read, valid with mem_ack |
| mem_ack | input | 1 | Memory has completed the request |
| sp_out | output | 32 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Misaligned stack pointer, command refused |
| res_val | output | 32 | Popped word |
| res_dst | output | 4 | Register index for res_val |
| res_wen | output | 1 | res_val is to be written |
| pc_val | output | 32 | New program counter |
| pc_wen | output | 1 | pc_val is to be taken |

## Verification
The assertions hold several rules on every cycle. A pending request stays stable until it is acknowledged. Every completion comes from an acknowledge or from an error. A refused command leaves the pointer alone and makes no memory request. A write lowers the pointer to exactly the written address, and the result strobes appear only with a good completion. Other properties need a memory model, so only the bench's scenarios show them. These are the values that come back on pop and return, including byte order across a push then pop. They also include the pointer loaded from memory on a pop into the stack pointer, the misalignment that load can create, and commands dropped while busy. The bench also varies acknowledge latency.

// File: rtl/stack_seq_pkg.sv
// Shared types of the stack sequencer.
// Assumes: command code values are fixed by the decoder that drives cmd_op.
package stack_seq_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } stk_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } stk_state_e;

    // True for the commands that write memory and lower the pointer.
    function automatic logic op_writes(stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
// Sequencing FSM: accepts one command when idle, holds a memory request
// until acknowledged and produces the one-cycle done/err pulses.
// Assumes: mem_ack is only meaningful while mem_req is high.
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  stk_op_e cmd_op,
    input  logic    misaligned,
    input  logic    mem_ack,
    output logic    accept,
    output logic    start,
    output logic    finish,
    output stk_op_e op_q,
    output logic    busy,
    output logic    mem_req,
    output logic    mem_we,
    output logic    done,
    output logic    err
);

    stk_state_e state_q;

    // Command handshake and memory completion strobes.
    always_comb begin
        accept  = (state_q == ST_IDLE) && cmd_valid;
        start   = accept && !misaligned;
        busy    = (state_q == ST_WAIT);
        mem_req = busy;
        mem_we  = op_writes(op_q);
        finish  = busy && mem_ack;
    end

    // State, latched command and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PUSH;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q <= cmd_op;
                        if (misaligned) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_ack) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stack_seq_sp.sv
// Stack-pointer register with access address and write-data latches.
// Lowers the pointer before a write, raises it after a read, or loads the
// read word when a pop targets the pointer itself.
// Assumes: start and finish never occur in the same cycle.
module stack_seq_sp
    import stack_seq_pkg::*;
#(
    parameter int          WORD_W  = 32,
    parameter logic [31:0] SP_INIT = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  stk_op_e           cmd_op,
    input  logic [WORD_W-1:0] src_val,
    input  logic [WORD_W-1:0] next_pc,
    input  logic              finish,
    input  stk_op_e           op_q,
    input  logic              load_sp,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] sp,
    output logic              misaligned,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam int STEP_BYTES = WORD_W / 8;
    localparam int ALIGN_W    = $clog2(STEP_BYTES);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(STEP_BYTES);

    logic [WORD_W-1:0] sp_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    // Alignment test only exists when a word spans more than one byte.
    generate
        if (ALIGN_W == 0) begin : g_no_align
            assign misaligned = 1'b0;
        end else begin : g_align
            assign misaligned = |sp_q[ALIGN_W-1:0];
        end
    endgenerate

    // Latch the access address and write word when a command starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= op_writes(cmd_op) ? (sp_q - STEP) : sp_q;
            wdata_q <= (cmd_op == OP_CALL) ? next_pc : src_val;
        end
    end

    // Commit the new stack pointer at the acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= WORD_W'(SP_INIT);
        end else if (finish) begin
            if (op_writes(op_q)) begin
                sp_q <= addr_q;
            end else if (load_sp) begin
                sp_q <= mem_rdata;
            end else begin
                sp_q <= addr_q + STEP;
            end
        end
    end

    assign sp        = sp_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/stack_seq_result.sv
// Result stage: keeps destination and call target of the running command
// and presents register and program-counter write-back at completion.
// Assumes: finish is high for a single cycle per command.
module stack_seq_result
    import stack_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int REG_W  = 4,
    parameter int SP_REG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  cmd_dst,
    input  logic [WORD_W-1:0] call_target,
    input  logic              finish,
    input  stk_op_e           op_q,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              load_sp,
    output logic [WORD_W-1:0] res_val,
    output logic [REG_W-1:0]  res_dst,
    output logic              res_wen,
    output logic [WORD_W-1:0] pc_val,
    output logic              pc_wen
);

    logic [REG_W-1:0]  dst_q;
    logic [WORD_W-1:0] tgt_q;

    // A pop that names the pointer register reloads the pointer.
    assign load_sp = (op_q == OP_POP) && (dst_q == REG_W'(SP_REG));

    // Capture operands of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            tgt_q <= '0;
        end else if (start) begin
            dst_q <= cmd_dst;
            tgt_q <= call_target;
        end
    end

    // Write-back values and one-cycle enables at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_val <= '0;
            res_dst <= '0;
            res_wen <= 1'b0;
            pc_val  <= '0;
            pc_wen  <= 1'b0;
        end else begin
            res_wen <= 1'b0;
            pc_wen  <= 1'b0;
            if (finish) begin
                unique case (op_q)
                    OP_POP: begin
                        res_val <= mem_rdata;
                        res_dst <= dst_q;
                        res_wen <= 1'b1;
                    end
                    OP_RET: begin
                        pc_val <= mem_rdata;
                        pc_wen <= 1'b1;
                    end
                    OP_CALL: begin
                        pc_val <= tgt_q;
                        pc_wen <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/stack_seq.sv
// Top of the stack sequencer: ties the FSM, the pointer datapath and the
// result stage together.
// Assumes: the memory returns one whole little-endian word per request.
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int          WORD_W  = 32,
    parameter int          REG_W   = 4,
    parameter int          SP_REG  = 4,
    parameter logic [31:0] SP_INIT = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [REG_W-1:0]  cmd_dst,
    input  logic [WORD_W-1:0] src_val,
    input  logic [WORD_W-1:0] call_target,
    input  logic [WORD_W-1:0] next_pc,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [WORD_W-1:0] sp_out,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] res_val,
    output logic [REG_W-1:0]  res_dst,
    output logic              res_wen,
    output logic [WORD_W-1:0] pc_val,
    output logic              pc_wen
);

    stk_op_e op_in;
    stk_op_e op_q;
    logic    accept;
    logic    start;
    logic    finish;
    logic    misaligned;
    logic    load_sp;

    assign op_in = stk_op_e'(cmd_op);

    stack_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_in),
        .misaligned (misaligned),
        .mem_ack    (mem_ack),
        .accept     (accept),
        .start      (start),
        .finish     (finish),
        .op_q       (op_q),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .done       (done),
        .err        (err)
    );

    stack_seq_sp #(
        .WORD_W  (WORD_W),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_op     (op_in),
        .src_val    (src_val),
        .next_pc    (next_pc),
        .finish     (finish),
        .op_q       (op_q),
        .load_sp    (load_sp),
        .mem_rdata  (mem_rdata),
        .sp         (sp_out),
        .misaligned (misaligned),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    stack_seq_result #(
        .WORD_W (WORD_W),
        .REG_W  (REG_W),
        .SP_REG (SP_REG)
    ) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd_dst     (cmd_dst),
        .call_target (call_target),
        .finish      (finish),
        .op_q        (op_q),
        .mem_rdata   (mem_rdata),
        .load_sp     (load_sp),
        .res_val     (res_val),
        .res_dst     (res_dst),
        .res_wen     (res_wen),
        .pc_val      (pc_val),
        .pc_wen      (pc_wen)
    );

endmodule

// File: rtl/stack_seq_chk.sv
// Checker for the stack sequencer, attached to every stack_seq instance.
// Assumes: reset is applied for at least one clock at start.
module stack_seq_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [WORD_W-1:0] sp_out,
    input logic              done,
    input logic              err,
    input logic              res_wen,
    input logic              pc_wen
);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> $past(mem_req && mem_ack));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_req);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && $stable(sp_out) && !$past(mem_req) && !res_wen && !pc_wen);

    // R2
    write_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> sp_out == $past(mem_addr));

    // R3
    res_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wen |-> done && !err && !pc_wen);

    // R4
    pc_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wen |-> done && !err);

endmodule

bind stack_seq stack_seq_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .sp_out    (sp_out),
    .done      (done),
    .err       (err),
    .res_wen   (res_wen),
    .pc_wen    (pc_wen)
);

// File: tb/sim_stack_seq.sv
// Bench: behavioural reference model compared on every falling edge,
// plus a byte-array memory with programmable acknowledge latency.
module sim_stack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_dst = 4'd0;
    logic [31:0] src_val = '0;
    logic [31:0] call_target = '0;
    logic [31:0] next_pc = '0;
    logic        busy, mem_req, mem_we, done, err, res_wen, pc_wen;
    logic [31:0] mem_addr, mem_wdata, sp_out, res_val, pc_val;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [3:0]  res_dst;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int wait_cnt = 0;
    bit finished = 1'b0;

    logic [7:0] mem_b [logic [31:0]];

    // reference model state
    bit          m_wait, m_done, m_err, m_rw, m_pw;
    logic [31:0] m_sp, m_addr, m_wd, m_tgt, m_rv, m_pc;
    logic [1:0]  m_op;
    logic [3:0]  m_dst, m_rd;

    always #2.5 clk = ~clk;

    stack_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dst(cmd_dst), .src_val(src_val), .call_target(call_target),
        .next_pc(next_pc), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .sp_out(sp_out), .done(done), .err(err),
        .res_val(res_val), .res_dst(res_dst), .res_wen(res_wen),
        .pc_val(pc_val), .pc_wen(pc_wen)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        logic [31:0] w;
        for (int i = 0; i < 4; i++)
            w[8*i +: 8] = mem_b.exists(a + i) ? mem_b[a + i] : 8'h00;
        return w;
    endfunction

    // Reference model: advances on each rising edge from sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sp = 32'h100; m_wait = 0; m_done = 0; m_err = 0; m_rw = 0; m_pw = 0;
        end else begin
            m_done = 0; m_err = 0; m_rw = 0; m_pw = 0;
            if (m_wait) begin
                if (mem_ack) begin
                    m_wait = 0; m_done = 1;
                    if (m_op == 2'd0 || m_op == 2'd2) begin
                        for (int i = 0; i < 4; i++) mem_b[m_addr + i] = m_wd[8*i +: 8];
                        m_sp = m_addr;
                        if (m_op == 2'd2) begin m_pw = 1; m_pc = m_tgt; end
                    end else begin
                        logic [31:0] w;
                        w = rd_word(m_addr);
                        if (m_op == 2'd1) begin
                            m_rw = 1; m_rv = w; m_rd = m_dst;
                            m_sp = (m_dst == 4'd4) ? w : m_addr + 4;
                        end else begin
                            m_pw = 1; m_pc = w; m_sp = m_addr + 4;
                        end
                    end
                end
            end else if (cmd_valid) begin
                if (m_sp[1:0] != 2'b00) begin
                    m_done = 1; m_err = 1;
                end else begin
                    m_wait = 1; m_op = cmd_op; m_dst = cmd_dst; m_tgt = call_target;
                    m_addr = (cmd_op == 2'd0 || cmd_op == 2'd2) ? m_sp - 4 : m_sp;
                    m_wd = (cmd_op == 2'd2) ? next_pc : src_val;
                end
            end
        end
    end

    // Per-cycle comparison, then the memory responder.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_wait, "R6", "busy", 32'(busy), 32'(m_wait));
            chk(mem_req == m_wait, "R6", "mem_req", 32'(mem_req), 32'(m_wait));
            chk(done == m_done, "R6", "done", 32'(done), 32'(m_done));
            chk(err == m_err, "R8", "err", 32'(err), 32'(m_err));
            chk(sp_out == m_sp, "R2", "sp_out", sp_out, m_sp);
            chk(res_wen == m_rw, "R3", "res_wen", 32'(res_wen), 32'(m_rw));
            chk(pc_wen == m_pw, "R4", "pc_wen", 32'(pc_wen), 32'(m_pw));
            if (m_wait) begin
                chk(mem_addr == m_addr, "R6", "mem_addr", mem_addr, m_addr);
                chk(mem_we == (m_op == 2'd0 || m_op == 2'd2), "R6", "mem_we",
                    32'(mem_we), 32'(m_op == 2'd0 || m_op == 2'd2));
                if (mem_we) chk(mem_wdata == m_wd, "R2", "mem_wdata", mem_wdata, m_wd);
            end
            if (m_rw) begin
                chk(res_val == m_rv, "R3", "res_val", res_val, m_rv);
                chk(res_dst == m_rd, "R3", "res_dst", 32'(res_dst), 32'(m_rd));
            end
            if (m_pw) chk(pc_val == m_pc, "R5", "pc_val", pc_val, m_pc);
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                mem_rdata = rd_word(mem_addr);
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // Issue one command; optionally pulse a stray command while busy.
    task automatic run(input logic [1:0] op, input logic [3:0] dst,
                       input logic [31:0] sv, input logic [31:0] tg,
                       input logic [31:0] np, input int l, input bit stray);
        lat = l;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_dst = dst;
        src_val = sv; call_target = tg; next_pc = np;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (stray && busy) begin
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_dst = 4'd9;
            src_val = 32'hDEAD_BEEF; call_target = 32'h0; next_pc = 32'h0;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sp_out == 32'h100, "R1", "reset sp", sp_out, 32'h100);
        chk({busy, done, err, mem_req, res_wen, pc_wen} == 6'b0, "R1", "reset flags",
            32'({busy, done, err, mem_req, res_wen, pc_wen}), 32'h0);
        rst_n = 1'b1;

        run(2'd0, 4'd0, 32'hA1B2_C3D4, 32'h0, 32'h0, 0, 0);
        chk(sp_out == 32'hFC, "R2", "push lowers sp", sp_out, 32'hFC);
        run(2'd0, 4'd0, 32'h1122_3344, 32'h0, 32'h0, 3, 0);
        chk(sp_out == 32'hF8, "R6", "slow ack push", sp_out, 32'hF8);
        run(2'd2, 4'd0, 32'h0, 32'h400, 32'h2A, 1, 0);
        chk(pc_wen && pc_val == 32'h400, "R4", "call target", pc_val, 32'h400);
        chk(sp_out == 32'hF4, "R4", "call sp", sp_out, 32'hF4);
        run(2'd3, 4'd0, 32'h0, 32'h0, 32'h0, 2, 0);
        chk(pc_wen && pc_val == 32'h2A, "R5", "ret pc", pc_val, 32'h2A);
        chk(!res_wen, "R5", "ret no res", 32'(res_wen), 32'h0);
        chk(sp_out == 32'hF8, "R5", "ret sp", sp_out, 32'hF8);
        run(2'd1, 4'd1, 32'h0, 32'h0, 32'h0, 2, 1);
        chk(res_wen && res_val == 32'h1122_3344, "R9", "stray ignored, pop value",
            res_val, 32'h1122_3344);
        chk(res_dst == 4'd1, "R3", "pop dst", 32'(res_dst), 32'h1);
        chk(sp_out == 32'hFC, "R9", "stray ignored, sp", sp_out, 32'hFC);
        run(2'd1, 4'd2, 32'h0, 32'h0, 32'h0, 0, 0);
        chk(res_val == 32'hA1B2_C3D4, "R3", "pop little-endian round trip",
            res_val, 32'hA1B2_C3D4);
        chk(sp_out == 32'h100, "R3", "pop sp", sp_out, 32'h100);
        run(2'd0, 4'd0, 32'h0000_00F2, 32'h0, 32'h0, 1, 0);
        run(2'd1, 4'd4, 32'h0, 32'h0, 32'h0, 1, 0);
        chk(sp_out == 32'hF2, "R7", "pop into sp", sp_out, 32'hF2);
        run(2'd0, 4'd0, 32'h5555_5555, 32'h0, 32'h0, 0, 0);
        chk(err && done, "R8", "push misaligned err", 32'(err), 32'h1);
        chk(sp_out == 32'hF2, "R8", "misaligned sp kept", sp_out, 32'hF2);
        run(2'd3, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0);
        chk(err && !pc_wen, "R8", "ret misaligned err", 32'(err), 32'h1);
        repeat (3) @(negedge clk);
        chk(!mem_req && sp_out == 32'hF2, "R8", "no access after err", sp_out, 32'hF2);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule